// File: doc/BRIEF.md
# NOR flash command sequencer

This block runs the command protocol of a 32-bit flash bus built from two 16-bit NOR devices side by side. A client hands it one operation at a time: an identifier probe, a block erase, a single-word program, or a plain return to read-array mode. The block turns that operation into the writes and reads the devices expect. Every command byte goes out in the low byte of both 16-bit halves at once.

Erase and program do not finish when their last command is written. The block then polls the status word until both devices report ready, or until a programmable number of polls has been used up. It always puts the devices back into read-array mode. Only after that does it report pass or fail. A program is also read back and compared with the word that was written.

The flash side is a simple synchronous bus. Each access is a single-cycle request carrying a direction, a word address and write data. A read is answered later by a single-cycle data-valid strobe. Pin timing and any bit permutation between this bus and the devices are left to the bus controller.

Top module: `nor_cmd_seq`

## Requirements
- R1: Each command word holds the command byte in bits 7:0 and in bits 23:16, with zeros elsewhere. The words are: read array 0x00FF00FF, identifier 0x00900090, erase setup 0x00200020, erase confirm 0x00D000D0, program setup 0x00400040, read status 0x00700070.
- R2: An erase (reqOp=2) first writes 0x00200020 and then writes 0x00D000D0, both to reqAddr.
- R3: A program (reqOp=3) first writes 0x00400040 and then writes reqData, both to reqAddr.
- R4: After its second write, an erase or program repeats a pair of accesses: a write of 0x00700070 to reqAddr, then a read of reqAddr. The loop ends only when bit 7 and bit 23 of the returned status are both set. A status with only one of those bits set keeps the loop going.
- R5: Every operation writes 0x00FF00FF as its last write before it reports a result. A read-array request (reqOp=0) performs exactly one write: 0x00FF00FF to reqAddr. It then reports success.
- R6: An erase fails if the final status has bit 5 or bit 21 set.
- R7: A program fails if the final status has bit 4 or bit 20 set. It also fails if a read of reqAddr made after the read-array write does not return reqData.
- R8: A probe (reqOp=1) writes 0x00900090 to address 0, reads address 0 (manufacturer) and address 1 (device), then writes 0x00FF00FF to address 0. It passes only if the manufacturer word is 0x00890089 and the device word is 0x88F388F3 or 0x88F488F4.
- R9: The number of status reads is limited to pollLimit, which is sampled when the request is accepted; a limit of 0 acts as 1. When the last allowed read is still not ready, the poll stops and the operation still ends with read-array. It then reports a failure.
- R10: busy rises in the cycle after a request is accepted and stays high through the single cycle in which doneValid is high. doneFail is meaningful in that cycle. A request presented while busy is high is ignored.
- R11: Each bus access is one cycle of fbReq, with fbWrite high for writes. After a read request, no new access is issued until fbRvalid has been returned.
- R12: While and after reset, with no request, busy, doneValid and fbReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start an operation (accepted when busy is low) |
| reqOp | input | 2 | 0 read array, 1 probe, 2 erase, 3 program |
| reqAddr | input | ADDR_W | Target word address |
| reqData | input | 32 | Word to program |
| pollLimit | input | POLL_W | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| doneValid | output | 1 | One-cycle result strobe |
| doneFail | output | 1 | Result: 1 = device error, timeout, mismatch or bad identifier |
| fbReq | output | 1 | Bus access request |
| fbWrite | output | 1 | Access is a write |
| fbAddr | output | ADDR_W | Bus word address |
| fbWdata | output | 32 | Bus write data |
| fbRvalid | input | 1 | Read response strobe |
| fbRdata | input | 32 | Read response data |

## Verification
The bench aims at four cases:
- A status word where only one half reports ready. A design that tested either bit instead of both would stop polling early and leave one device still busy.
- An error bit set in only one half, for both erase and program. A design that required the bit in both halves would report a failed erase as good.
- A poll limit that expires, including a limit of zero. A wrong design would either hang or skip the closing read-array write.
- A program whose read-back differs from the data, and probe words where only one half or only the device code is wrong. Here an over-lenient compare would pass a bad part.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int HALF_W = 16;
  localparam int NUM_DEV = 2;
  localparam int WORD_W = HALF_W * NUM_DEV;

  // command bytes, placed in the low byte of every device half
  localparam logic [7:0] CB_ARRAY  = 8'hFF;
  localparam logic [7:0] CB_IDENT  = 8'h90;
  localparam logic [7:0] CB_ESETUP = 8'h20;
  localparam logic [7:0] CB_ECONF  = 8'hD0;
  localparam logic [7:0] CB_PSETUP = 8'h40;
  localparam logic [7:0] CB_STATUS = 8'h70;

  // status bits within one half
  localparam logic [HALF_W-1:0] HB_READY   = 16'h0080;
  localparam logic [HALF_W-1:0] HB_ERASEER = 16'h0020;
  localparam logic [HALF_W-1:0] HB_PROGER  = 16'h0010;

  // identifier values per half
  localparam logic [HALF_W-1:0] ID_MAKER = 16'h0089;
  localparam logic [HALF_W-1:0] ID_DEVA  = 16'h88F3;
  localparam logic [HALF_W-1:0] ID_DEVB  = 16'h88F4;

  typedef enum logic [1:0] {
    OP_ARRAY = 2'd0,
    OP_PROBE = 2'd1,
    OP_ERASE = 2'd2,
    OP_PROG  = 2'd3
  } opKind_t;

  typedef enum logic [2:0] {
    WS_ARRAY, WS_IDENT, WS_ESETUP, WS_ECONF, WS_PSETUP, WS_STATUS, WS_DATA
  } wsrc_t;

  typedef enum logic [1:0] {
    AS_REQ, AS_ZERO, AS_ONE
  } asrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  latchReq;
    wsrc_t wsrc;
    asrc_t asrc;
    logic  capStatus;
    logic  capMaker;
    logic  capDevice;
    logic  capVerify;
    logic  pollInc;
  } strobe_t;

  function automatic logic [WORD_W-1:0] dupHalf(input logic [HALF_W-1:0] h);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < NUM_DEV; i++) w[i*HALF_W +: HALF_W] = h;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] dupCmd(input logic [7:0] c);
    return dupHalf({8'h00, c});
  endfunction

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [WORD_W-1:0] fbRdata,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [WORD_W-1:0] fbWdata,
  output logic              statusReady,
  output logic              pollExpired,
  output logic              resultFail
);

  localparam logic [WORD_W-1:0] W_ERASEER = dupHalf(HB_ERASEER);
  localparam logic [WORD_W-1:0] W_PROGER  = dupHalf(HB_PROGER);
  localparam logic [WORD_W-1:0] W_MAKER   = dupHalf(ID_MAKER);
  localparam logic [WORD_W-1:0] W_DEVA    = dupHalf(ID_DEVA);
  localparam logic [WORD_W-1:0] W_DEVB    = dupHalf(ID_DEVB);
  localparam int CNT_W = POLL_W + 1;

  opKind_t           opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;
  logic [POLL_W-1:0] limitReg;
  logic [POLL_W-1:0] pollCnt;
  logic [WORD_W-1:0] statusReg;
  logic [WORD_W-1:0] makerReg;
  logic [WORD_W-1:0] deviceReg;
  logic              verifyBad;
  logic              timedOut;
  logic [NUM_DEV-1:0] halfReady;
  logic [CNT_W-1:0]  nextCnt;

  // per-device ready bit
  for (genvar g = 0; g < NUM_DEV; g++) begin : gReady
    assign halfReady[g] = |(fbRdata[g*HALF_W +: HALF_W] & HB_READY);
  end
  assign statusReady = &halfReady;

  assign nextCnt     = {1'b0, pollCnt} + CNT_W'(1);
  assign pollExpired = nextCnt >= {1'b0, limitReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= OP_ARRAY;
      addrReg   <= '0;
      dataReg   <= '0;
      limitReg  <= '0;
      pollCnt   <= '0;
      statusReg <= '0;
      makerReg  <= '0;
      deviceReg <= '0;
      verifyBad <= 1'b0;
      timedOut  <= 1'b0;
    end else begin
      if (stb.latchReq) begin
        opReg     <= opKind_t'(reqOp);
        addrReg   <= reqAddr;
        dataReg   <= reqData;
        limitReg  <= pollLimit;
        pollCnt   <= '0;
        statusReg <= '0;
        makerReg  <= '0;
        deviceReg <= '0;
        verifyBad <= 1'b0;
        timedOut  <= 1'b0;
      end
      if (stb.pollInc)   pollCnt   <= pollCnt + POLL_W'(1);
      if (stb.capStatus) begin
        statusReg <= fbRdata;
        timedOut  <= !statusReady && pollExpired;
      end
      if (stb.capMaker)  makerReg  <= fbRdata;
      if (stb.capDevice) deviceReg <= fbRdata;
      if (stb.capVerify) verifyBad <= (fbRdata != dataReg);
    end
  end

  always_comb begin
    unique case (stb.asrc)
      AS_ZERO: fbAddr = '0;
      AS_ONE:  fbAddr = ADDR_W'(1);
      default: fbAddr = addrReg;
    endcase
  end

  always_comb begin
    unique case (stb.wsrc)
      WS_IDENT:  fbWdata = dupCmd(CB_IDENT);
      WS_ESETUP: fbWdata = dupCmd(CB_ESETUP);
      WS_ECONF:  fbWdata = dupCmd(CB_ECONF);
      WS_PSETUP: fbWdata = dupCmd(CB_PSETUP);
      WS_STATUS: fbWdata = dupCmd(CB_STATUS);
      WS_DATA:   fbWdata = dataReg;
      default:   fbWdata = dupCmd(CB_ARRAY);
    endcase
  end

  always_comb begin
    unique case (opReg)
      OP_PROBE: resultFail = !((makerReg == W_MAKER) &&
                               ((deviceReg == W_DEVA) || (deviceReg == W_DEVB)));
      OP_ERASE: resultFail = timedOut || (|(statusReg & W_ERASEER));
      OP_PROG:  resultFail = timedOut || (|(statusReg & W_PROGER)) || verifyBad;
      default:  resultFail = 1'b0;
    endcase
  end

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       fbRvalid,
  input  logic       statusReady,
  input  logic       pollExpired,
  output strobe_t    stb,
  output logic       fbReq,
  output logic       fbWrite,
  output logic       busy,
  output logic       doneValid
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_SECOND, S_POLLCMD, S_POLLREQ, S_POLLWAIT,
    S_ID0REQ, S_ID0WAIT, S_ID1REQ, S_ID1WAIT,
    S_ARRAY, S_VREQ, S_VWAIT, S_DONE
  } state_t;

  state_t  state, stateNext;
  opKind_t opReg;
  logic    busWr, busRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_ARRAY;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && reqValid) opReg <= opKind_t'(reqOp);
    end
  end

  always_comb begin
    stb       = '0;
    stb.wsrc  = WS_ARRAY;
    stb.asrc  = (opReg == OP_PROBE) ? AS_ZERO : AS_REQ;
    busWr     = 1'b0;
    busRd     = 1'b0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        stb.asrc = AS_REQ;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext = (opKind_t'(reqOp) == OP_ARRAY) ? S_ARRAY : S_SETUP;
        end
      end
      S_SETUP: begin
        busWr = 1'b1;
        unique case (opReg)
          OP_PROBE: stb.wsrc = WS_IDENT;
          OP_ERASE: stb.wsrc = WS_ESETUP;
          default:  stb.wsrc = WS_PSETUP;
        endcase
        stateNext = (opReg == OP_PROBE) ? S_ID0REQ : S_SECOND;
      end
      S_SECOND: begin
        busWr     = 1'b1;
        stb.wsrc  = (opReg == OP_ERASE) ? WS_ECONF : WS_DATA;
        stateNext = S_POLLCMD;
      end
      S_POLLCMD: begin
        busWr     = 1'b1;
        stb.wsrc  = WS_STATUS;
        stateNext = S_POLLREQ;
      end
      S_POLLREQ: begin
        busRd     = 1'b1;
        stateNext = S_POLLWAIT;
      end
      S_POLLWAIT: begin
        if (fbRvalid) begin
          stb.capStatus = 1'b1;
          if (statusReady || pollExpired) begin
            stateNext = S_ARRAY;
          end else begin
            stb.pollInc = 1'b1;
            stateNext = S_POLLCMD;
          end
        end
      end
      S_ID0REQ: begin
        busRd     = 1'b1;
        stb.asrc  = AS_ZERO;
        stateNext = S_ID0WAIT;
      end
      S_ID0WAIT: begin
        if (fbRvalid) begin
          stb.capMaker = 1'b1;
          stateNext = S_ID1REQ;
        end
      end
      S_ID1REQ: begin
        busRd     = 1'b1;
        stb.asrc  = AS_ONE;
        stateNext = S_ID1WAIT;
      end
      S_ID1WAIT: begin
        if (fbRvalid) begin
          stb.capDevice = 1'b1;
          stateNext = S_ARRAY;
        end
      end
      S_ARRAY: begin
        busWr     = 1'b1;
        stb.wsrc  = WS_ARRAY;
        stateNext = (opReg == OP_PROG) ? S_VREQ : S_DONE;
      end
      S_VREQ: begin
        busRd     = 1'b1;
        stateNext = S_VWAIT;
      end
      S_VWAIT: begin
        if (fbRvalid) begin
          stb.capVerify = 1'b1;
          stateNext = S_DONE;
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign fbReq     = busWr || busRd;
  assign fbWrite   = busWr;
  assign busy      = (state != S_IDLE);
  assign doneValid = (state == S_DONE);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busy,
  output logic              doneValid,
  output logic              doneFail,
  output logic              fbReq,
  output logic              fbWrite,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [31:0]       fbWdata,
  input  logic              fbRvalid,
  input  logic [31:0]       fbRdata
);

  strobe_t stb;
  logic    statusReady, pollExpired, resultFail;

  nor_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .fbRvalid(fbRvalid), .statusReady(statusReady), .pollExpired(pollExpired),
    .stb(stb), .fbReq(fbReq), .fbWrite(fbWrite), .busy(busy), .doneValid(doneValid)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .pollLimit(pollLimit), .fbRdata(fbRdata),
    .fbAddr(fbAddr), .fbWdata(fbWdata), .statusReady(statusReady),
    .pollExpired(pollExpired), .resultFail(resultFail)
  );

  assign doneFail = doneValid && resultFail;

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              doneValid,
  input logic              fbReq,
  input logic              fbWrite,
  input logic [ADDR_W-1:0] fbAddr,
  input logic [31:0]       fbWdata,
  input logic              fbRvalid
);

  logic readOut;
  logic lastWasArray;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readOut      <= 1'b0;
      lastWasArray <= 1'b0;
    end else begin
      if (fbReq && !fbWrite) readOut <= 1'b1;
      else if (fbRvalid)     readOut <= 1'b0;
      if (fbReq && fbWrite)  lastWasArray <= (fbWdata == dupCmd(CB_ARRAY));
    end
  end

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busy);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !fbReq);
  assert_one_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fbReq && readOut) |-> fbRvalid);
  assert_array_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> lastWasArray);

  // address stays on-bus only while requesting is not required; unused here
  logic unusedAddr;
  assign unusedAddr = ^fbAddr;

endmodule

bind nor_cmd_seq nor_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .doneValid(doneValid), .fbReq(fbReq), .fbWrite(fbWrite),
  .fbAddr(fbAddr), .fbWdata(fbWdata), .fbRvalid(fbRvalid)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

  localparam int ADDR_W = 20;
  localparam int POLL_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              reqValid = 1'b0;
  logic [1:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqData = '0;
  logic [POLL_W-1:0] pollLimit = '0;
  logic              busy, doneValid, doneFail, fbReq, fbWrite;
  logic [ADDR_W-1:0] fbAddr;
  logic [31:0]       fbWdata;
  logic              fbRvalid = 1'b0;
  logic [31:0]       fbRdata = '0;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .pollLimit(pollLimit),
    .busy(busy), .doneValid(doneValid), .doneFail(doneFail),
    .fbReq(fbReq), .fbWrite(fbWrite), .fbAddr(fbAddr), .fbWdata(fbWdata),
    .fbRvalid(fbRvalid), .fbRdata(fbRdata)
  );

  // ---------------- flash pair model ----------------
  int          cfgBusy = 0;
  logic        cfgHalf = 1'b0;
  logic [31:0] cfgErr = '0;
  logic        cfgCorrupt = 1'b0;
  logic [31:0] cfgMaker = '0;
  logic [31:0] cfgDevice = '0;
  logic        modelClr = 1'b0;

  logic [31:0] mem [16] = '{default: 32'hFFFFFFFF};
  logic [1:0]  mode = 2'd0;   // 0 array, 1 id, 2 status
  logic        expectData = 1'b0;
  int          statReads = 0;
  int          wrCount = 0;
  logic [31:0] w0d = '0, w1d = '0, lastWd = '0;
  logic [ADDR_W-1:0] w0a = '0, w1a = '0;

  always @(posedge clk) begin
    fbRvalid <= 1'b0;
    if (modelClr) begin
      statReads <= 0;
      wrCount   <= 0;
      lastWd    <= '0;
    end else if (fbReq) begin
      if (fbWrite) begin
        wrCount <= wrCount + 1;
        lastWd  <= fbWdata;
        if (wrCount == 0) begin w0d <= fbWdata; w0a <= fbAddr; end
        if (wrCount == 1) begin w1d <= fbWdata; w1a <= fbAddr; end
        if (expectData) begin
          mem[fbAddr[3:0]] <= cfgCorrupt ? (fbWdata ^ 32'h1) : fbWdata;
          expectData <= 1'b0;
          mode <= 2'd2;
        end else begin
          case (fbWdata)
            32'h00FF00FF: mode <= 2'd0;
            32'h00900090: mode <= 2'd1;
            32'h00700070: mode <= 2'd2;
            32'h00400040: expectData <= 1'b1;
            32'h00D000D0: begin mem[fbAddr[3:0]] <= 32'hFFFFFFFF; mode <= 2'd2; end
            default: ;
          endcase
        end
      end else begin
        fbRvalid <= 1'b1;
        case (mode)
          2'd1: fbRdata <= (fbAddr == 0) ? cfgMaker : (fbAddr == 1) ? cfgDevice : 32'h0;
          2'd2: begin
            fbRdata <= (statReads >= cfgBusy) ? (32'h00800080 | cfgErr)
                                              : (cfgHalf ? 32'h00000080 : 32'h0);
            statReads <= statReads + 1;
          end
          default: fbRdata <= mem[fbAddr[3:0]];
        endcase
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] addr;
    logic [31:0] data;
    logic [7:0]  busyPolls;
    logic        halfFirst;
    logic [31:0] errWord;
    logic        corrupt;
    logic [31:0] maker;
    logic [31:0] device;
    logic [15:0] limit;
    logic        expFail;
    logic [7:0]  expPolls;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R2 R4 erase, ready after 3 busy polls
    '{2'd2, 20'h00123, 32'h0, 8'd3, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd20, 1'b0, 8'd4},
    // R6 erase error in low half only
    '{2'd2, 20'h00124, 32'h0, 8'd0, 1'b0, 32'h00000020, 1'b0, 32'h0, 32'h0, 16'd20, 1'b1, 8'd1},
    // R4 one half ready early must keep polling
    '{2'd2, 20'h00005, 32'h0, 8'd2, 1'b1, 32'h0, 1'b0, 32'h0, 32'h0, 16'd20, 1'b0, 8'd3},
    // R3 program good
    '{2'd3, 20'h00045, 32'hA5A55A5A, 8'd1, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd20, 1'b0, 8'd2},
    // R7 program error in high half
    '{2'd3, 20'h00046, 32'h12345678, 8'd0, 1'b0, 32'h00100000, 1'b0, 32'h0, 32'h0, 16'd20, 1'b1, 8'd1},
    // R7 program read-back mismatch
    '{2'd3, 20'h00047, 32'h0F0F0F0F, 8'd0, 1'b0, 32'h0, 1'b1, 32'h0, 32'h0, 16'd20, 1'b1, 8'd1},
    // R8 probe good, first device code
    '{2'd1, 20'h00099, 32'h0, 8'd0, 1'b0, 32'h0, 1'b0, 32'h00890089, 32'h88F388F3, 16'd20, 1'b0, 8'd0},
    // R8 probe good, second device code
    '{2'd1, 20'h00099, 32'h0, 8'd0, 1'b0, 32'h0, 1'b0, 32'h00890089, 32'h88F488F4, 16'd20, 1'b0, 8'd0},
    // R8 probe unknown device
    '{2'd1, 20'h00000, 32'h0, 8'd0, 1'b0, 32'h0, 1'b0, 32'h00890089, 32'h88F188F1, 16'd20, 1'b1, 8'd0},
    // R8 probe maker wrong in one half
    '{2'd1, 20'h00000, 32'h0, 8'd0, 1'b0, 32'h0, 1'b0, 32'h00890000, 32'h88F388F3, 16'd20, 1'b1, 8'd0},
    // R9 poll timeout after 5 reads
    '{2'd2, 20'h00200, 32'h0, 8'd50, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd5, 1'b1, 8'd5},
    // R5 read-array request
    '{2'd0, 20'h00077, 32'h0, 8'd0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd20, 1'b0, 8'd0},
    // R9 limit zero acts as one
    '{2'd3, 20'h00008, 32'h11112222, 8'd5, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd0, 1'b1, 8'd1}
  };

  bit gotDone;
  bit gotFail;

  task automatic startOp(input vec_t v);
    @(negedge clk);
    cfgBusy = int'(v.busyPolls);
    cfgHalf = v.halfFirst;
    cfgErr = v.errWord;
    cfgCorrupt = v.corrupt;
    cfgMaker = v.maker;
    cfgDevice = v.device;
    modelClr = 1'b1;
    @(negedge clk);
    modelClr = 1'b0;
    reqValid = 1'b1;
    reqOp = v.op;
    reqAddr = v.addr;
    reqData = v.data;
    pollLimit = v.limit;
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'h1);
  endtask

  task automatic waitDone(input int holdCycles);
    gotDone = 1'b0;
    gotFail = 1'b0;
    for (int c = 0; c < 3000 && !gotDone; c++) begin
      if (c >= holdCycles) reqValid = 1'b0;
      if (doneValid) begin
        gotDone = 1'b1;
        gotFail = doneFail;
      end else begin
        @(negedge clk);
      end
    end
    reqValid = 1'b0;
    check(gotDone, "R10", "operation completes", 32'(gotDone), 32'h1);
  endtask

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check(!busy && !doneValid && !fbReq, "R12", "quiet in reset",
          {29'h0, busy, doneValid, fbReq}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !doneValid && !fbReq, "R12", "quiet after reset",
          {29'h0, busy, doneValid, fbReq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int expWr;
      v = VECS[i];
      startOp(v);
      waitDone(0);
      check(gotFail == v.expFail, "R6 R7 R8 R9", $sformatf("vector %0d result", i),
            32'(gotFail), 32'(v.expFail));
      check(lastWd == 32'h00FF00FF, "R5", $sformatf("vector %0d last write", i),
            lastWd, 32'h00FF00FF);
      check(statReads == int'(v.expPolls), "R4 R9", $sformatf("vector %0d status reads", i),
            32'(statReads), 32'(v.expPolls));
      case (v.op)
        2'd0: expWr = 1;
        2'd1: expWr = 2;
        default: expWr = 3 + int'(v.expPolls);
      endcase
      check(wrCount == expWr, "R4", $sformatf("vector %0d write count", i),
            32'(wrCount), 32'(expWr));
      if (v.op == 2'd2) begin
        check(w0d == 32'h00200020 && w0a == v.addr, "R2", "erase setup word", w0d, 32'h00200020);
        check(w1d == 32'h00D000D0 && w1a == v.addr, "R2", "erase confirm word", w1d, 32'h00D000D0);
      end
      if (v.op == 2'd3) begin
        check(w0d == 32'h00400040 && w0a == v.addr, "R3", "program setup word", w0d, 32'h00400040);
        check(w1d == v.data && w1a == v.addr, "R3", "program data word", w1d, v.data);
      end
      if (v.op == 2'd1)
        check(w0d == 32'h00900090 && w0a == '0, "R8", "identifier command", w0d, 32'h00900090);
      if (v.op == 2'd0)
        check(w0a == v.addr, "R5", "read-array address", 32'(w0a), 32'(v.addr));
      if (v.op == 2'd2 && v.busyPolls == 8'd3)
        check(32'h00700070 == 32'h00700070 && statReads == 4, "R1", "status polls counted",
              32'(statReads), 32'h4);
      @(negedge clk);
      check(!doneValid && !busy, "R10", "done is a single cycle",
            {30'h0, doneValid, busy}, 32'h0);
    end

    // R10 request held high while busy is ignored
    begin
      vec_t v;
      v = '{2'd2, 20'h00300, 32'h0, 8'd2, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd20, 1'b0, 8'd3};
      startOp(v);
      reqOp = 2'd0;
      waitDone(4);
      repeat (4) @(negedge clk);
      check(wrCount == 6, "R10", "no second op from held request", 32'(wrCount), 32'd6);
      check(!busy, "R10", "idle after ignored request", 32'(busy), 32'h0);
      check(w0d == 32'h00200020, "R1", "erase setup byte in both halves", w0d, 32'h00200020);
    end

    // R3 R7 programmed word readable through read-array path
    begin
      vec_t v;
      v = '{2'd3, 20'h0000A, 32'hCAFEF00D, 8'd0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 16'd4, 1'b0, 8'd1};
      startOp(v);
      waitDone(0);
      check(!gotFail, "R7", "clean program passes", 32'(gotFail), 32'h0);
      check(mem[4'hA] == 32'hCAFEF00D, "R3", "word stored", mem[4'hA], 32'hCAFEF00D);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule